// File: doc/BRIEF.md
# Ordered Keypad Test Sequencer

This block runs a factory keypad check. After a start pulse it expects every key of the keypad once, in a fixed order. Key `k` is the expected key at step `k`. After the last key it waits for one clockwise turn of the jog dial, then one counter-clockwise turn. A key scanner that already debounces supplies the pressed-key vector, and a jog decoder supplies one-cycle direction events. The block reports which step it is waiting on. When it sees a wrong key, or more than one key pressed together, it shows an error for a fixed time and then stays on the same step. When the run ends it gives a done pulse, with a flag that says whether an operator abort ended the run.

A correct press of the first key also asks the infrared transmitter for one burst of a preset code. The burst length is FRAMES frames, and the transmitter owns that count. An operator can skip a step or abandon the test. The skip is refused while the sequencer waits for the clockwise turn. The abandon is refused while it waits for the counter-clockwise turn. The error hold time is set in milliseconds and converted to clock cycles from the clock frequency parameter.

Top module: `keypad_test_seq`

## Requirements
- R1: After reset, active_o, err_o, ir_req_o, done_o and aborted_o are 0 and step_o is 0. A start_i pulse while inactive sets active_o to 1 with step_o at 0 from the next cycle.
- R2: Key k is bit k of key_n_i and is pressed when that bit is 0. On a key step, a press of exactly the expected key (index equal to step_o) raises step_o by one in the next cycle.
- R3: On a key step, a press of a key other than the expected one, or a press of two or more keys in the same cycle, raises err_o for exactly HOLD cycles (CLK_HZ*HOLD_MS/1000). step_o does not change.
- R4: While err_o is high, key presses, skip_i and next_i have no effect on step_o, active_o or done_o.
- R5: A press is registered only in the cycle where the number of pressed keys goes from zero to non-zero. Keys that stay held, or are added while others are held, cause neither an advance nor an error.
- R6: ir_req_o pulses for one cycle, in the same cycle that step_o goes from 0 to 1, and only when a correct press of key 0 caused that change. A skip does not raise it.
- R7: After the last key step, step_o equals NKEYS and the block waits for jog_cw_i. That event moves step_o to NKEYS+1, and then jog_ccw_i ends the run: done_o pulses with aborted_o at 0 and active_o falls. Keys and jog events in the wrong direction are ignored on these steps.
- R8: skip_i advances one step on a key step, ends the run normally on step NKEYS+1, and is ignored on step NKEYS.
- R9: next_i ends the run with done_o and aborted_o both pulsing on any active step except NKEYS+1. On step NKEYS+1 it is ignored. At the end of any run, step_o returns to 0.
- R10: When inputs arrive in the same cycle, next_i has priority over skip_i, and skip_i has priority over a key press or jog event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a test run (ignored while active) |
| key_n_i | input | NKEYS | Debounced key states, 0 = pressed |
| jog_cw_i | input | 1 | One-cycle clockwise jog event |
| jog_ccw_i | input | 1 | One-cycle counter-clockwise jog event |
| skip_i | input | 1 | Operator skip request |
| next_i | input | 1 | Operator abandon request |
| active_o | output | 1 | A run is in progress |
| step_o | output | $clog2(NKEYS+2) | Index of the expected step |
| err_o | output | 1 | Error display hold in progress |
| ir_req_o | output | 1 | Request for one infrared frame burst |
| done_o | output | 1 | One-cycle end-of-run pulse |
| aborted_o | output | 1 | Qualifies done_o: run was abandoned |

## Verification
A full in-order pass over all keys checks that single correct presses advance one step each and that only the first key requests the infrared burst. A wrong single key and a two-key chord are each followed by the measured error hold. The bench counts the exact hold length, and presses, skips and abandon requests made during the hold must leave the step unchanged. A correct key held while a second key is added separates edge-based press detection from level-based detection. Skip, abandon and simultaneous-input cases on the two jog steps confirm the refused escapes and the priority order.

// File: rtl/kts_pkg.sv
package kts_pkg;

    localparam int KEY_CODE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_KEYS  = 2'd1,
        PH_JOG_R = 2'd2,
        PH_JOG_L = 2'd3
    } phase_e;

    typedef struct packed {
        logic                  valid;
        logic                  single;
        logic [KEY_CODE_W-1:0] code;
    } key_evt_t;

    function automatic int hold_cycles(longint clk_hz, int hold_ms);
        longint c;
        c = (clk_hz * longint'(hold_ms)) / 64'sd1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/kts_key_decode.sv
module kts_key_decode
    import kts_pkg::*;
#(
    parameter int NKEYS      = 32,
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NKEYS-1:0] keys_i,
    output key_evt_t         evt_o
);
    localparam int CNTW = $clog2(NKEYS + 1);

    logic [NKEYS-1:0] pressed;
    logic [CNTW-1:0]  cnt;
    logic [KEY_CODE_W-1:0] code;
    logic             any_q;

    for (genvar g = 0; g < NKEYS; g++) begin : g_pol
        if (ACTIVE_LOW) begin : g_low
            assign pressed[g] = ~keys_i[g];
        end else begin : g_high
            assign pressed[g] = keys_i[g];
        end
    end

    always_comb begin
        cnt  = '0;
        code = '0;
        for (int i = NKEYS - 1; i >= 0; i--) begin
            if (pressed[i]) begin
                cnt  = cnt + CNTW'(1);
                code = KEY_CODE_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= (cnt != '0);
    end

    always_comb begin
        evt_o.valid  = (cnt != '0) && !any_q;
        evt_o.single = (cnt == CNTW'(1));
        evt_o.code   = code;
    end
endmodule

// File: rtl/kts_hold_timer.sv
module kts_hold_timer #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            left_q <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o <= 1'b1;
                left_q <= HW'(HOLD_CYC - 1);
            end
        end else if (left_q == '0) begin
            busy_o <= 1'b0;
        end else begin
            left_q <= left_q - HW'(1);
        end
    end
endmodule

// File: rtl/kts_seq_ctrl.sv
module kts_seq_ctrl
    import kts_pkg::*;
#(
    parameter int NKEYS = 32,
    parameter int STEPW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  key_evt_t         evt_i,
    input  logic             jog_cw_i,
    input  logic             jog_ccw_i,
    input  logic             skip_i,
    input  logic             next_i,
    input  logic             busy_i,
    output logic             err_start_o,
    output logic             active_o,
    output logic [STEPW-1:0] step_o,
    output logic             ir_req_o,
    output logic             done_o,
    output logic             aborted_o
);
    localparam logic [STEPW-1:0] LAST_KEY = STEPW'(NKEYS - 1);

    phase_e           phase_q;
    logic [STEPW-1:0] step_q;
    logic             key_ok;

    assign key_ok = evt_i.valid && evt_i.single &&
                    (int'(evt_i.code) == int'(step_q));

    assign err_start_o = (phase_q == PH_KEYS) && !busy_i && !next_i &&
                         !skip_i && evt_i.valid && !key_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            step_q    <= '0;
            ir_req_o  <= 1'b0;
            done_o    <= 1'b0;
            aborted_o <= 1'b0;
        end else begin
            ir_req_o  <= 1'b0;
            done_o    <= 1'b0;
            aborted_o <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_KEYS;
                        step_q  <= '0;
                    end
                end
                PH_KEYS: begin
                    if (!busy_i) begin
                        if (next_i) begin
                            phase_q   <= PH_IDLE;
                            step_q    <= '0;
                            done_o    <= 1'b1;
                            aborted_o <= 1'b1;
                        end else if (skip_i || key_ok) begin
                            step_q   <= step_q + STEPW'(1);
                            ir_req_o <= key_ok && !skip_i && (step_q == '0);
                            if (step_q == LAST_KEY) phase_q <= PH_JOG_R;
                        end
                    end
                end
                PH_JOG_R: begin
                    if (next_i) begin
                        phase_q   <= PH_IDLE;
                        step_q    <= '0;
                        done_o    <= 1'b1;
                        aborted_o <= 1'b1;
                    end else if (!skip_i && jog_cw_i) begin
                        phase_q <= PH_JOG_L;
                        step_q  <= step_q + STEPW'(1);
                    end
                end
                PH_JOG_L: begin
                    if (skip_i || jog_ccw_i) begin
                        phase_q <= PH_IDLE;
                        step_q  <= '0;
                        done_o  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign active_o = (phase_q != PH_IDLE);
    assign step_o   = step_q;
endmodule

// File: rtl/keypad_test_seq.sv
module keypad_test_seq
    import kts_pkg::*;
#(
    parameter int     NKEYS   = 32,
    parameter longint CLK_HZ  = 250_000_000,
    parameter int     HOLD_MS = 1000,
    parameter int     STEPW   = $clog2(NKEYS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NKEYS-1:0] key_n_i,
    input  logic             jog_cw_i,
    input  logic             jog_ccw_i,
    input  logic             skip_i,
    input  logic             next_i,
    output logic             active_o,
    output logic [STEPW-1:0] step_o,
    output logic             err_o,
    output logic             ir_req_o,
    output logic             done_o,
    output logic             aborted_o
);
    localparam int HOLD_CYC = hold_cycles(CLK_HZ, HOLD_MS);

    key_evt_t evt;
    logic     err_start;
    logic     busy;

    kts_key_decode #(.NKEYS(NKEYS), .ACTIVE_LOW(1'b1)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .keys_i (key_n_i),
        .evt_o  (evt)
    );

    kts_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .start_i (err_start),
        .busy_o  (busy)
    );

    kts_seq_ctrl #(.NKEYS(NKEYS), .STEPW(STEPW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .evt_i       (evt),
        .jog_cw_i    (jog_cw_i),
        .jog_ccw_i   (jog_ccw_i),
        .skip_i      (skip_i),
        .next_i      (next_i),
        .busy_i      (busy),
        .err_start_o (err_start),
        .active_o    (active_o),
        .step_o      (step_o),
        .ir_req_o    (ir_req_o),
        .done_o      (done_o),
        .aborted_o   (aborted_o)
    );

    assign err_o = busy;
endmodule

// File: rtl/keypad_test_seq_chk.sv
module keypad_test_seq_chk #(
    parameter int NKEYS    = 32,
    parameter int STEPW    = 6,
    parameter int HOLD_CYC = 1000
) (
    input logic             clk,
    input logic             rst,
    input logic             jog_ccw_i,
    input logic             skip_i,
    input logic             next_i,
    input logic             active_o,
    input logic [STEPW-1:0] step_o,
    input logic             err_o,
    input logic             ir_req_o,
    input logic             done_o,
    input logic             aborted_o
);
    int unsigned err_len_q;

    always_ff @(posedge clk) begin
        if (rst)        err_len_q <= 0;
        else if (err_o) err_len_q <= err_len_q + 1;
        else            err_len_q <= 0;
    end

    AST_STEP_ONE_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step_o != $past(step_o)) |-> (step_o == $past(step_o) + STEPW'(1) || step_o == '0)); // R2

    AST_ERR_KEEPS_STEP: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(step_o)); // R4

    AST_ERR_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (err_len_q < HOLD_CYC)); // R3

    AST_ERR_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(err_o) |-> (err_len_q == HOLD_CYC)); // R3

    AST_IR_ON_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
        ir_req_o |-> (step_o == STEPW'(1) && $past(step_o) == '0)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_ABORT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        aborted_o |-> (done_o && !active_o)); // R9

    AST_NO_SKIP_JOG_R: assert property (@(posedge clk) disable iff (rst)
        (active_o && step_o == STEPW'(NKEYS) && skip_i && !next_i) |=> (step_o == STEPW'(NKEYS))); // R8

    AST_NO_NEXT_JOG_L: assert property (@(posedge clk) disable iff (rst)
        (active_o && step_o == STEPW'(NKEYS + 1) && next_i && !skip_i && !jog_ccw_i) |=> !done_o); // R9
endmodule

bind keypad_test_seq keypad_test_seq_chk #(
    .NKEYS(NKEYS), .STEPW(STEPW), .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk(clk), .rst(rst), .jog_ccw_i(jog_ccw_i), .skip_i(skip_i), .next_i(next_i),
    .active_o(active_o), .step_o(step_o), .err_o(err_o), .ir_req_o(ir_req_o),
    .done_o(done_o), .aborted_o(aborted_o)
);

// File: tb/keypad_test_seq_bench.sv
module keypad_test_seq_bench;
    localparam int NKEYS   = 6;
    localparam int STEPW   = $clog2(NKEYS + 2);
    localparam int HOLD    = 50;   // 50 Hz clock * 1000 ms / 1000

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [NKEYS-1:0] key_n_i = '1;
    logic             jog_cw_i = 1'b0, jog_ccw_i = 1'b0, skip_i = 1'b0, next_i = 1'b0;
    logic             active_o, err_o, ir_req_o, done_o, aborted_o;
    logic [STEPW-1:0] step_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    keypad_test_seq #(.NKEYS(NKEYS), .CLK_HZ(50), .HOLD_MS(1000)) u_keypad_test_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .key_n_i(key_n_i),
        .jog_cw_i(jog_cw_i), .jog_ccw_i(jog_ccw_i), .skip_i(skip_i), .next_i(next_i),
        .active_o(active_o), .step_o(step_o), .err_o(err_o), .ir_req_o(ir_req_o),
        .done_o(done_o), .aborted_o(aborted_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic begin_run();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic press(int k);
        key_n_i[k] = 1'b0; tick();
        key_n_i = '1; tick();
    endtask

    task automatic t_reset();
        chk("R1", "active after reset", active_o, 0);
        chk("R1", "step after reset", step_o, 0);
        chk("R1", "err after reset", err_o, 0);
        chk("R1", "done after reset", done_o, 0);
        chk("R1", "ir after reset", ir_req_o, 0);
        begin_run();
        chk("R1", "active after start", active_o, 1);
        chk("R1", "step after start", step_o, 0);
        next_i = 1'b1; tick(); next_i = 1'b0; tick();
    endtask

    task automatic t_full_pass();
        begin_run();
        for (int i = 0; i < NKEYS; i++) begin
            key_n_i[i] = 1'b0; tick();
            chk("R2", "step after correct key", step_o, i + 1);
            chk("R6", "ir request", ir_req_o, (i == 0) ? 1 : 0);
            chk("R3", "no error on correct key", err_o, 0);
            key_n_i = '1; tick();
            chk("R6", "ir pulse length", ir_req_o, 0);
        end
        key_n_i[0] = 1'b0; tick(); key_n_i = '1; tick();
        chk("R7", "key ignored on jog step", step_o, NKEYS);
        chk("R7", "no error on jog step", err_o, 0);
        jog_ccw_i = 1'b1; tick(); jog_ccw_i = 1'b0;
        chk("R7", "wrong jog ignored", step_o, NKEYS);
        chk("R7", "still active", active_o, 1);
        jog_cw_i = 1'b1; tick(); jog_cw_i = 1'b0;
        chk("R7", "step after right jog", step_o, NKEYS + 1);
        jog_cw_i = 1'b1; tick(); jog_cw_i = 1'b0;
        chk("R7", "right jog ignored on left step", done_o, 0);
        jog_ccw_i = 1'b1; tick(); jog_ccw_i = 1'b0;
        chk("R7", "done after left jog", done_o, 1);
        chk("R7", "not aborted", aborted_o, 0);
        chk("R7", "inactive at end", active_o, 0);
        chk("R9", "step back to zero", step_o, 0);
        tick();
        chk("R7", "done is a pulse", done_o, 0);
    endtask

    task automatic t_error_hold();
        int len;
        begin_run();
        key_n_i[2] = 1'b0; tick();
        chk("R3", "err on wrong key", err_o, 1);
        chk("R3", "step kept on wrong key", step_o, 0);
        len = 1;
        key_n_i = '1; tick(); len++;
        key_n_i[0] = 1'b0; tick(); len++;
        chk("R4", "correct key ignored in hold", step_o, 0);
        key_n_i = '1; tick(); len++;
        skip_i = 1'b1; tick(); skip_i = 1'b0; len++;
        chk("R4", "skip ignored in hold", step_o, 0);
        next_i = 1'b1; tick(); next_i = 1'b0; len++;
        chk("R4", "next ignored in hold", done_o, 0);
        chk("R4", "still active in hold", active_o, 1);
        while (err_o && len < 10 * HOLD) begin
            tick();
            if (err_o) len++;
        end
        chk("R3", "error hold length", len, HOLD);
        chk("R4", "step after hold", step_o, 0);
        press(0);
        chk("R2", "advance after hold", step_o, 1);
        key_n_i[1] = 1'b0; key_n_i[2] = 1'b0; tick();
        chk("R3", "err on chord", err_o, 1);
        chk("R3", "step kept on chord", step_o, 1);
        key_n_i = '1;
        while (err_o) tick();
        press(1);
        chk("R2", "advance after chord hold", step_o, 2);
        next_i = 1'b1; tick(); next_i = 1'b0; tick();
    endtask

    task automatic t_no_repeat();
        begin_run();
        key_n_i[0] = 1'b0; tick();
        chk("R5", "first press accepted", step_o, 1);
        tick();
        key_n_i[1] = 1'b0; tick(); tick();
        chk("R5", "added key not registered", step_o, 1);
        chk("R5", "added key no error", err_o, 0);
        key_n_i = '1; tick();
        press(1);
        chk("R5", "press after release", step_o, 2);
        next_i = 1'b1; tick(); next_i = 1'b0; tick();
    endtask

    task automatic t_skip();
        begin_run();
        skip_i = 1'b1; tick(); skip_i = 1'b0;
        chk("R8", "skip advances key step", step_o, 1);
        chk("R6", "skip gives no ir", ir_req_o, 0);
        for (int i = 1; i < NKEYS; i++) press(i);
        chk("R8", "at right jog step", step_o, NKEYS);
        skip_i = 1'b1; tick(); skip_i = 1'b0;
        chk("R8", "skip refused on right jog", step_o, NKEYS);
        skip_i = 1'b1; jog_cw_i = 1'b1; tick(); skip_i = 1'b0; jog_cw_i = 1'b0;
        chk("R10", "skip with right jog", step_o, NKEYS);
        jog_cw_i = 1'b1; tick(); jog_cw_i = 1'b0;
        skip_i = 1'b1; tick(); skip_i = 1'b0;
        chk("R8", "skip ends on left jog", done_o, 1);
        chk("R8", "skip end not aborted", aborted_o, 0);
        tick();
    endtask

    task automatic t_next();
        begin_run();
        press(0);
        next_i = 1'b1; tick(); next_i = 1'b0;
        chk("R9", "next ends run", done_o, 1);
        chk("R9", "next sets aborted", aborted_o, 1);
        chk("R9", "inactive after next", active_o, 0);
        chk("R9", "step zero after next", step_o, 0);
        tick();
        begin_run();
        for (int i = 0; i < NKEYS; i++) begin
            skip_i = 1'b1; tick(); skip_i = 1'b0;
        end
        jog_cw_i = 1'b1; tick(); jog_cw_i = 1'b0;
        next_i = 1'b1; tick(); next_i = 1'b0;
        chk("R9", "next refused on left jog", done_o, 0);
        chk("R9", "still on left jog", step_o, NKEYS + 1);
        jog_ccw_i = 1'b1; tick(); jog_ccw_i = 1'b0;
        chk("R7", "left jog finishes", done_o, 1);
        tick();
    endtask

    task automatic t_priority();
        begin_run();
        key_n_i[0] = 1'b0; next_i = 1'b1; tick(); next_i = 1'b0;
        chk("R10", "next beats key", aborted_o, 1);
        chk("R10", "no ir when next wins", ir_req_o, 0);
        key_n_i = '1; tick();
        begin_run();
        key_n_i[3] = 1'b0; skip_i = 1'b1; tick(); skip_i = 1'b0;
        chk("R10", "skip beats wrong key", step_o, 1);
        chk("R10", "no error when skip wins", err_o, 0);
        key_n_i = '1; tick();
        next_i = 1'b1; tick(); next_i = 1'b0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_full_pass();
        t_error_hold();
        t_no_repeat();
        t_skip();
        t_next();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule